// File: doc/BRIEF.md
# Smart Charger Status Word

This block assembles the 16-bit status word that a host reads from a smart battery charger over an SMBus-style register interface. Most bits are live copies of comparator flags: AC presence, power failure, thermistor threshold flags, over-range flags and regulation-loop states. Three bits are fixed capability bits.

Two flags are sticky latches. The alarm-inhibit latch is set by alarm-warning writes. It is cleared by battery removal, by a mode write carrying the power-on-reset bit, or by any charging-voltage or charging-current write. The thermistor-hot latch captures a hot thermistor reading and holds it until the battery is removed or a power-on-reset mode write arrives. The block also drives a charge-inhibit control. This control is high when no battery is present or when either latch is set, and it is mirrored in bit 0 of the word.

Writes arrive as a one-cycle strobe with an 8-bit command code and 16 data bits. Reading the word has no side effects.

Top module: `chg_status_word`

## Requirements
- R1: Live flags are mapped at fixed bit positions: voltage-not-regulating at bit 2, current-not-regulating at bit 3, current over-range at bit 6, voltage over-range at bit 7, thermistor-cold at bit 9, thermistor under-range at bit 11, power-fail at bit 13, AC-present at bit 15. Each of these follows its input in the same cycle.
- R2: Bit 4 always reads 1. Bits 1 and 5 always read 0.
- R3: Bit 8 copies the thermistor over-range input. Bit 14 (battery present) is its inverse.
- R4: A write of command 0x16 (alarm warning) with data bit 15, 14 or 12 high sets the alarm-inhibit latch, which is reported at bit 12 from the next cycle. A write with only other data bits high leaves the latch unchanged.
- R5: The alarm-inhibit latch clears on the edge after any of these: the battery is absent, a write of command 0x12 (mode) with data bit 3 high, a write of command 0x15 (charging voltage), or a write of command 0x14 (charging current).
- R6: The thermistor-hot latch sets on the edge after the hot comparator input is high. It is reported at bit 10 and holds after that input falls.
- R7: The thermistor-hot latch clears on the edge after the battery is absent or after a mode write with data bit 3 high.
- R8: When a set condition and a clear condition of a latch occur in the same cycle, the latch ends cleared.
- R9: The charge_inhibit output and status bit 0 equal (battery absent) OR (alarm-inhibit latch) OR (thermistor-hot latch).
- R10: Reset clears both latches. A mode write with data bit 3 low, and writes of other command codes, leave both latches unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ac_ok | input | 1 | AC adapter present flag |
| pwr_fail | input | 1 | Battery voltage near input voltage flag |
| thm_ovr | input | 1 | Thermistor above over-range threshold (no battery) |
| thm_cold | input | 1 | Thermistor above cold threshold |
| thm_hot_raw | input | 1 | Thermistor below hot threshold |
| thm_undr | input | 1 | Thermistor below under-range threshold |
| cur_ovr | input | 1 | Requested current beyond capability |
| vlt_ovr | input | 1 | Requested voltage beyond capability |
| cur_unreg | input | 1 | Battery current below set point |
| vlt_unreg | input | 1 | Battery voltage below set point |
| wr_en | input | 1 | One-cycle register-write strobe |
| wr_cmd | input | 8 | Command code of the write |
| wr_data | input | 16 | Data of the write |
| status | output | 16 | Status word |
| charge_inhibit | output | 1 | Charger-off control |

## Verification
The latch assertions assume that wr_cmd and wr_data are meaningful only while wr_en is high. They also assume that all flags are synchronous to clk and stable around the edge. The stimulus drives every input on the falling edge only, and it chooses commands from the four defined codes plus unused codes. The battery-absent flag is kept rare so that latch states last long enough to be observed. Directed cases pair set and clear conditions in the same cycle.

// File: rtl/chg_status_word.sv
module chg_status_word #(
  parameter logic [7:0] CMD_MODE  = 8'h12,
  parameter logic [7:0] CMD_CURR  = 8'h14,
  parameter logic [7:0] CMD_VOLT  = 8'h15,
  parameter logic [7:0] CMD_ALARM = 8'h16,
  parameter int         POR_BIT   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ac_ok,
  input  logic        pwr_fail,
  input  logic        thm_ovr,
  input  logic        thm_cold,
  input  logic        thm_hot_raw,
  input  logic        thm_undr,
  input  logic        cur_ovr,
  input  logic        vlt_ovr,
  input  logic        cur_unreg,
  input  logic        vlt_unreg,
  input  logic        wr_en,
  input  logic [7:0]  wr_cmd,
  input  logic [15:0] wr_data,
  output logic [15:0] status,
  output logic        charge_inhibit
);

  logic alarm_q, hot_q;
  logic por_wr, alarm_set, alarm_clr, hot_set, hot_clr;

  assign por_wr    = wr_en && wr_cmd == CMD_MODE && wr_data[POR_BIT];
  assign alarm_set = wr_en && wr_cmd == CMD_ALARM &&
                     (wr_data[15] || wr_data[14] || wr_data[12]);
  assign alarm_clr = thm_ovr || por_wr ||
                     (wr_en && (wr_cmd == CMD_VOLT || wr_cmd == CMD_CURR));
  assign hot_set   = thm_hot_raw;
  assign hot_clr   = thm_ovr || por_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm_q <= 1'b0;
      hot_q   <= 1'b0;
    end else begin
      if (alarm_clr)      alarm_q <= 1'b0;
      else if (alarm_set) alarm_q <= 1'b1;
      if (hot_clr)        hot_q <= 1'b0;
      else if (hot_set)   hot_q <= 1'b1;
    end
  end

  assign charge_inhibit = thm_ovr | alarm_q | hot_q;

  assign status = {ac_ok, ~thm_ovr, pwr_fail, alarm_q,
                   thm_undr, hot_q, thm_cold, thm_ovr,
                   vlt_ovr, cur_ovr, 1'b0, 1'b1,
                   cur_unreg, vlt_unreg, 1'b0, charge_inhibit};

  AST_ALARM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_set && !alarm_clr |=> status[12]);                       // R4
  AST_ALARM_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_clr |=> !status[12]);                                     // R5
  AST_HOT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    thm_hot_raw && !thm_ovr && !por_wr |=> status[10]);             // R6
  AST_HOT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (thm_ovr || por_wr) |=> !status[10]);                           // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en && !thm_ovr && !thm_hot_raw |=> $stable(status[12]) && $stable(status[10])); // R10
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    thm_ovr && thm_hot_raw |=> !status[10] && !status[12]);         // R8

endmodule

// File: tb/chg_status_word_tb.sv
module chg_status_word_tb;
  localparam logic [7:0] MODE = 8'h12, CURR = 8'h14, VOLT = 8'h15, ALRM = 8'h16;

  logic clk = 0, rst_n = 0;
  logic ac_ok = 0, pwr_fail = 0, thm_ovr = 0, thm_cold = 0, thm_hot_raw = 0, thm_undr = 0;
  logic cur_ovr = 0, vlt_ovr = 0, cur_unreg = 0, vlt_unreg = 0, wr_en = 0;
  logic [7:0]  wr_cmd = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] status;
  logic        charge_inhibit;
  logic m_alarm = 0, m_hot = 0;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  chg_status_word u_dut (.*);

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (!rst_n) begin m_alarm = 0; m_hot = 0; end
    else begin
      logic por, aclr, aset, hclr;
      por  = wr_en && wr_cmd == MODE && wr_data[3];
      aclr = thm_ovr || por || (wr_en && (wr_cmd == VOLT || wr_cmd == CURR));
      aset = wr_en && wr_cmd == ALRM && (wr_data[15] || wr_data[14] || wr_data[12]);
      hclr = thm_ovr || por;
      if (aclr) m_alarm = 0; else if (aset) m_alarm = 1;
      if (hclr) m_hot = 0;   else if (thm_hot_raw) m_hot = 1;
    end
    @(negedge clk);
  endtask

  task automatic check_all();
    logic inh;
    #1;
    inh = thm_ovr | m_alarm | m_hot;
    chk("R1 live flags", status & 16'hAACC,
        {ac_ok, 1'b0, pwr_fail, 1'b0, thm_undr, 1'b0, thm_cold, 1'b0,
         vlt_ovr, cur_ovr, 2'b00, cur_unreg, vlt_unreg, 2'b00});
    chk("R2 fixed bits", status & 16'h0032, 16'h0010);
    chk("R3 presence", {status[14], status[8]}, {~thm_ovr, thm_ovr});
    chk("R4 alarm latch", status[12], m_alarm);
    chk("R6 hot latch", status[10], m_hot);
    chk("R9 inhibit", {status[0], charge_inhibit}, {inh, inh});
  endtask

  task automatic wr(input logic [7:0] c, input logic [15:0] d);
    wr_en = 1; wr_cmd = c; wr_data = d;
    tick();
    wr_en = 0; wr_data = 0;
  endtask

  initial begin
    #2_000_000;
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    @(negedge clk);
    tick(); tick();
    chk("R10 reset latches", {status[12], status[10]}, 2'b00);
    rst_n = 1;
    tick();
    check_all();
    // R4: each setting bit; bit 13 alone does not set
    wr(ALRM, 16'h2000); chk("R4 bit13 ignored", status[12], 1'b0);
    wr(ALRM, 16'h8000); chk("R4 set by bit15", status[12], 1'b1);
    wr(VOLT, 16'h0000); chk("R5 clear by voltage write", status[12], 1'b0);
    wr(ALRM, 16'h4000); chk("R4 set by bit14", status[12], 1'b1);
    wr(CURR, 16'h0000); chk("R5 clear by current write", status[12], 1'b0);
    wr(ALRM, 16'h1000); chk("R4 set by bit12", status[12], 1'b1);
    wr(MODE, 16'hFFF7); chk("R10 mode without POR keeps alarm", status[12], 1'b1);
    wr(8'h33, 16'hFFFF); chk("R10 other command keeps alarm", status[12], 1'b1);
    wr(MODE, 16'h0008); chk("R5 clear by POR mode write", status[12], 1'b0);
    // R6/R7 hot latch
    thm_hot_raw = 1; tick(); thm_hot_raw = 0;
    chk("R6 hot set", status[10], 1'b1);
    tick(); chk("R6 hot holds", status[10], 1'b1);
    chk("R9 inhibit from hot", charge_inhibit, 1'b1);
    wr(MODE, 16'h0008); chk("R7 hot clear by POR", status[10], 1'b0);
    thm_hot_raw = 1; tick(); thm_hot_raw = 0;
    wr(ALRM, 16'h8000);
    thm_ovr = 1; tick(); thm_ovr = 0;
    #1 chk("R7 R5 clear by battery absent", {status[10], status[12]}, 2'b00);
    // R8 clear wins
    thm_ovr = 1; thm_hot_raw = 1; wr_en = 1; wr_cmd = ALRM; wr_data = 16'hF000;
    tick();
    chk("R8 clear wins", {status[10], status[12]}, 2'b00);
    thm_ovr = 0; thm_hot_raw = 0; wr_en = 0;
    wr(ALRM, 16'h8000);
    wr_en = 1; wr_cmd = MODE; wr_data = 16'h0008; thm_hot_raw = 1;
    tick();
    chk("R8 POR beats hot set", status[10], 1'b0);
    wr_en = 0; thm_hot_raw = 0;
    // random
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] cmds [6];
      cmds = '{MODE, CURR, VOLT, ALRM, 8'h00, 8'h3C};
      {ac_ok, pwr_fail, thm_cold, thm_undr, cur_ovr, vlt_ovr, cur_unreg, vlt_unreg} = 8'($urandom);
      thm_ovr     = ($urandom % 40) == 0;
      thm_hot_raw = ($urandom % 15) == 0;
      wr_en       = ($urandom % 4) == 0;
      wr_cmd      = cmds[$urandom % 6];
      wr_data     = 16'($urandom);
      check_all();
      tick();
    end
    wr_en = 0;
    check_all();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule